// File: doc/BRIEF.md
# Shift-Clock-Referenced Grayscale PWM Engine

This block drives twelve on/off channel enables from 16-bit grayscale words, using the rising edges of the serial data clock as its only time base. Each qualified serial-clock edge is one grayscale count, and one display period is exactly 65536 such edges. A period does not begin on its own. A latch event arms the engine, and the next serial-clock edge seen with the serial data line low starts the period at count zero. That edge also loads the grayscale words that the period will use.

A channel is on while the running count is below its grayscale word. A word of zero never lights the channel, and a word of 0xFFFF lights it for all but the last count of the period. When the period ends, the engine either goes idle with every channel off or wraps back to count zero and reloads the words, as the repeat control selects. A blanking input forces every channel off at once. A timing-reset control decides whether a latch that arrives during a period aborts that period.

The serial-clock strobe is a one-cycle pulse that is already synchronized to the block clock. The latch strobe is also a one-cycle pulse produced by the neighbouring latch logic.

Top module: `gspwm_engine`

## Requirements
- R1: After reset no period is running and every bit of `chan_on` is 0, whatever the grayscale input holds.
- R2: While `blank` is 1, every bit of `chan_on` is 0 in that same cycle. Blanking does not stop or alter the count, and the outputs follow the count again as soon as `blank` returns to 0.
- R3: While `ext_clk_mode` is 0, `sck_rise` strobes neither start a period nor advance the count.
- R4: After a latch pulse the engine is armed. The first `sck_rise` with `sdata` at 0 starts a period at count 0, and every channel with a nonzero word is on from the next cycle. A strobe with `sdata` at 1 leaves the engine armed and the outputs off.
- R5: Channel n (word at `gs_words[16n+15:16n]`) is on while the count is less than its word. A word of 0 is never on, and 0xFFFF is on for 65535 of the 65536 counts.
- R6: A period is 65536 strobes, including the starting one. With `repeat_en` at 0, the strobe that follows count 65535 ends the period, and all channels stay off until a new latch and start strobe.
- R7: With `repeat_en` at 1, the strobe that follows count 65535 returns the count to 0 and reloads the grayscale words, so the period repeats.
- R8: Grayscale words are captured only when a period starts or wraps. Changes on `gs_words` during a period have no effect on the outputs of that period.
- R9: A latch pulse during a period with `tmg_reset_en` at 1 aborts the period: all channels turn off and the engine is armed again. With `tmg_reset_en` at 0 such a latch pulse is ignored and the period continues.
- R10: The count changes only on cycles with an enabled `sck_rise`, so cycles without a strobe leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_mode | input | 1 | 1 selects the serial clock as the grayscale time base |
| tmg_reset_en | input | 1 | 1 lets a latch pulse abort a running period |
| repeat_en | input | 1 | 1 repeats the period, 0 runs a single period |
| blank | input | 1 | 1 forces all channels off |
| sck_rise | input | 1 | One-cycle strobe per serial-clock rising edge |
| sdata | input | 1 | Serial data level at that edge |
| latch_pulse | input | 1 | One-cycle strobe when new data has been latched |
| gs_words | input | 192 | Twelve 16-bit grayscale words, channel n at bits 16n+15:16n |
| chan_on | output | 12 | Channel enables, bit n for channel n |

## Verification
The hardest situation to reach is the end of a period: the stop or wrap only happens after 65536 strobes. The stimulus therefore asserts the strobe on every cycle, so that whole periods run to completion. This exposes the last-count behaviour of a 0xFFFF channel, the single-shot stop and the repeat wrap, with new grayscale words applied mid-period so that the reload at the wrap is visible. Aborting latches, ignored latches and strobes with the data line high are placed while the engine is armed or running, so each transition of the sequencer is reached from the ports.

// File: rtl/gspwm_pkg.sv
`timescale 1ns/1ps
package gspwm_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ARMED = 2'd1,
      SEQ_RUN   = 2'd2
   } seq_state_e;
endpackage

// File: rtl/gspwm_seq.sv
`timescale 1ns/1ps
module gspwm_seq
   import gspwm_pkg::*;
#(
   parameter int GS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ext_clk_mode,
   input  logic            tmg_reset_en,
   input  logic            repeat_en,
   input  logic            sck_rise,
   input  logic            sdata,
   input  logic            latch_pulse,
   output logic            running,
   output logic [GS_W-1:0] count,
   output logic            load
);
   localparam logic [GS_W-1:0] CNT_LAST = {GS_W{1'b1}};

   seq_state_e state;
   logic adv, start, at_last, wrap, abort;

   assign adv     = ext_clk_mode & sck_rise;
   assign at_last = (count == CNT_LAST);
   assign abort   = (state == SEQ_RUN) & latch_pulse & tmg_reset_en;
   assign start   = (state == SEQ_ARMED) & adv & ~sdata & ~latch_pulse;
   assign wrap    = (state == SEQ_RUN) & ~abort & adv & at_last & repeat_en;
   assign load    = start | wrap;
   assign running = (state == SEQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         count <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (latch_pulse) state <= SEQ_ARMED;
            end
            SEQ_ARMED: begin
               if (start) begin
                  state <= SEQ_RUN;
                  count <= '0;
               end
            end
            SEQ_RUN: begin
               if (abort) begin
                  state <= SEQ_ARMED;
               end else if (adv) begin
                  if (!at_last)        count <= count + 1'b1;
                  else if (repeat_en)  count <= '0;
                  else                 state <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // R10: without an enabled strobe, the running count holds
   p_hold_without_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !adv) |=> $stable(count));
   // R4: a start strobe begins the period at count zero
   p_start_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (running && count == '0));
   // R6: single-shot period ends after its last count
   p_single_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && adv && at_last && !repeat_en && !latch_pulse) |=> !running);
   // R7: repeat mode wraps to zero
   p_repeat_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && adv && at_last && repeat_en && !abort) |=> (running && count == '0));
   // R9: abort returns to armed state (not running)
   p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !running);
   // R3: with the shift clock deselected, an armed engine never starts
   p_no_start_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_clk_mode && !running) |=> !running);
endmodule

// File: rtl/gspwm_gs_bank.sv
`timescale 1ns/1ps
module gspwm_gs_bank #(
   parameter int CHANNELS = 12,
   parameter int GS_W     = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     running,
   input  logic [CHANNELS*GS_W-1:0] gs_in,
   output logic [CHANNELS*GS_W-1:0] gs_cur
);
   for (genvar n = 0; n < CHANNELS; n++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    gs_cur[n*GS_W +: GS_W] <= '0;
         else if (load) gs_cur[n*GS_W +: GS_W] <= gs_in[n*GS_W +: GS_W];
      end
   end

   // R8: captured words stay fixed during a period unless a start/wrap loads
   p_words_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !load) |=> $stable(gs_cur));
endmodule

// File: rtl/gspwm_cmp.sv
`timescale 1ns/1ps
module gspwm_cmp #(
   parameter int GS_W = 16
) (
   input  logic            enable,
   input  logic [GS_W-1:0] count,
   input  logic [GS_W-1:0] level,
   output logic            on
);
   assign on = enable & (count < level);

   // R5: a zero word never lights the channel
   always_comb begin
      p_zero_dark_r5: assert (!(level == '0 && on));
   end
endmodule

// File: rtl/gspwm_engine.sv
`timescale 1ns/1ps
module gspwm_engine #(
   parameter int CHANNELS = 12,
   parameter int GS_W     = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ext_clk_mode,
   input  logic                     tmg_reset_en,
   input  logic                     repeat_en,
   input  logic                     blank,
   input  logic                     sck_rise,
   input  logic                     sdata,
   input  logic                     latch_pulse,
   input  logic [CHANNELS*GS_W-1:0] gs_words,
   output logic [CHANNELS-1:0]      chan_on
);
   localparam int WORDS_W = CHANNELS * GS_W;

   if (CHANNELS < 1 || CHANNELS > 64) begin : g_bad_channels
      $error("gspwm_engine: CHANNELS must lie in 1..64");
   end
   if (GS_W < 2 || GS_W > 24) begin : g_bad_width
      $error("gspwm_engine: GS_W must lie in 2..24");
   end

   logic               running, load, drive_en;
   logic [GS_W-1:0]    count;
   logic [WORDS_W-1:0] gs_cur;

   gspwm_seq #(.GS_W(GS_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_clk_mode (ext_clk_mode),
      .tmg_reset_en (tmg_reset_en),
      .repeat_en    (repeat_en),
      .sck_rise     (sck_rise),
      .sdata        (sdata),
      .latch_pulse  (latch_pulse),
      .running      (running),
      .count        (count),
      .load         (load)
   );

   gspwm_gs_bank #(.CHANNELS(CHANNELS), .GS_W(GS_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .running (running),
      .gs_in   (gs_words),
      .gs_cur  (gs_cur)
   );

   assign drive_en = running & ~blank;

   for (genvar n = 0; n < CHANNELS; n++) begin : g_chan
      gspwm_cmp #(.GS_W(GS_W)) u_cmp (
         .enable (drive_en),
         .count  (count),
         .level  (gs_cur[n*GS_W +: GS_W]),
         .on     (chan_on[n])
      );
   end

   // R2: blanking darkens every channel
   p_blank_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> (chan_on == '0));
   // R6: outside a period every channel is dark
   p_idle_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (chan_on == '0));
   // R1: no period runs in the cycle after reset release
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !running);
endmodule

// File: tb/gspwm_engine_test.sv
`timescale 1ns/1ps
module gspwm_engine_test;
   localparam int CH = 12;
   localparam int W  = 16;
   localparam int LAST = 65535;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_clk_mode = 1'b1, tmg_reset_en = 1'b1, repeat_en = 1'b0, blank = 1'b0;
   logic sck_rise = 1'b0, sdata = 1'b0, latch_pulse = 1'b0;
   logic [CH*W-1:0] gs_words = '0;
   logic [CH-1:0]   chan_on;

   always #2.5 clk = ~clk;

   gspwm_engine #(.CHANNELS(CH), .GS_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .ext_clk_mode(ext_clk_mode),
      .tmg_reset_en(tmg_reset_en), .repeat_en(repeat_en), .blank(blank),
      .sck_rise(sck_rise), .sdata(sdata), .latch_pulse(latch_pulse),
      .gs_words(gs_words), .chan_on(chan_on));

   // configuration shadows, applied to the ports inside tick()
   bit c_ext = 1, c_tmr = 1, c_rpt = 0, c_blank = 0;
   int c_gs[CH];

   // reference model of the requirements
   int m_st = 0;   // 0 idle, 1 armed, 2 running
   int m_cnt = 0;
   int m_gs[CH];

   typedef struct { logic [CH-1:0] exp; string req; } item_t;
   item_t sb[$];
   int vectors = 0, miscompares = 0;
   bit done = 0;

   task automatic model_load();
      for (int n = 0; n < CH; n++) m_gs[n] = c_gs[n];
   endtask

   task automatic tick(bit s, bit d, bit l, string req);
      item_t it;
      bit adv;
      @(negedge clk);
      ext_clk_mode = c_ext; tmg_reset_en = c_tmr; repeat_en = c_rpt; blank = c_blank;
      for (int n = 0; n < CH; n++) gs_words[n*W +: W] = c_gs[n][W-1:0];
      sck_rise = s; sdata = d; latch_pulse = l;
      adv = c_ext && s;
      if (m_st == 2) begin
         if (l && c_tmr) m_st = 1;
         else if (adv) begin
            if (m_cnt == LAST) begin
               if (c_rpt) begin m_cnt = 0; model_load(); end
               else m_st = 0;
            end else m_cnt++;
         end
      end else if (l) m_st = 1;
      else if (m_st == 1 && adv && !d) begin
         m_st = 2; m_cnt = 0; model_load();
      end
      for (int n = 0; n < CH; n++)
         it.exp[n] = (m_st == 2) && !c_blank && (m_cnt < m_gs[n]);
      it.req = req;
      sb.push_back(it);
   endtask

   task automatic run(int k, bit s, bit d, string req);
      for (int i = 0; i < k; i++) tick(s, d, 1'b0, req);
   endtask

   // monitor: compare each pushed expectation just after its clock edge
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            vectors++;
            if (chan_on !== it.exp) begin
               miscompares++;
               if (miscompares < 20)
                  $display("FAIL %s: chan_on=%h expected=%h", it.req, chan_on, it.exp);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      c_gs[0] = 0; c_gs[1] = 1; c_gs[2] = 3; c_gs[3] = 16'hFFFF; c_gs[4] = 256;
      for (int n = 5; n < CH; n++) c_gs[n] = n * 40;
      for (int n = 0; n < CH; n++) m_gs[n] = 0;

      // R1: reset state, inputs active but held in reset
      for (int n = 0; n < CH; n++) gs_words[n*W +: W] = c_gs[n][W-1:0];
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         sck_rise = 1'b1; latch_pulse = (i == 1);
         vectors++;
         if (chan_on !== '0) begin
            miscompares++;
            $display("FAIL R1: chan_on=%h expected=%h", chan_on, {CH{1'b0}});
         end
      end
      @(negedge clk); sck_rise = 1'b0; latch_pulse = 1'b0; rst_n = 1'b1;
      run(3, 1, 0, "R1");

      // R4: arm, reject strobes with data high
      tick(0, 0, 1, "R4");
      run(3, 1, 1, "R4");
      // R3: strobes ignored with the shift clock deselected
      c_ext = 0;
      run(4, 1, 0, "R3");
      c_ext = 1;
      tick(1, 0, 0, "R4");
      run(10, 1, 0, "R5");
      // R10: no strobe, no change
      run(6, 0, 0, "R10");
      // R8: mid-period word change is ignored
      c_gs[1] = 500; c_gs[0] = 7; c_gs[2] = 1000;
      run(300, 1, 0, "R8");
      // R2: blank darkens, count keeps going
      c_blank = 1;
      run(20, 1, 0, "R2");
      c_blank = 0;
      run(250, 1, 0, "R2");
      // R9: aborting latch, then armed without a start
      tick(0, 0, 1, "R9");
      run(5, 1, 1, "R9");

      // R6: one full single-shot period, with an ignored latch inside
      c_tmr = 0;
      tick(1, 0, 0, "R6");
      run(100, 1, 0, "R5");
      tick(0, 0, 1, "R9");
      run(LAST - 100 - 5, 1, 0, "R5");
      run(5, 1, 0, "R6");
      run(10, 1, 0, "R6");

      // R7: repeating period with reload at the wrap
      c_tmr = 1; c_rpt = 1;
      tick(0, 0, 1, "R7");
      tick(1, 0, 0, "R7");
      run(1000, 1, 0, "R7");
      c_gs[0] = 40000; c_gs[1] = 0; c_gs[3] = 12; c_gs[4] = 2;
      run(LAST - 1000, 1, 0, "R8");
      run(600, 1, 0, "R7");

      repeat (3) @(posedge clk);
      #2;
      finish_run();
   end
endmodule